// File: doc/BRIEF.md
# Per-Output Short-Circuit Shutdown Timer Array

This block guards the twelve power switches of a six-channel half-bridge driver, one high-side and one low-side switch per half-bridge. The analog current regulator of each switch raises an overcurrent-limit flag while it is limiting. The block qualifies each flag over time. Only a switch that is commanded on and stays in current limit for the whole programmed delay is forced off. Once forced off, the switch stays off.

Each switch has its own timer, so a short on one output never shortens or extends the qualification of another. All timers advance on a shared timebase tick. One delay-select bit picks a short qualification time of 1.5 ms or a long one of 12 ms. The tick counts for both times are derived from the tick period parameter.

Any forced-off switch sets a shared short-detected flag. A status-reset pulse from the control register clears that flag and re-enables every tripped switch at once. There is no temperature input: a thermal warning during a short neither shortens nor extends the delay.

Top module: `sc_shutdown_array`

## Requirements
- R1: After reset, every disable flag and the short-detected flag are low, and every timer holds zero.
- R2: With delay select low (1.5 ms, 15 ticks of the default 100 us tick), a switch that is commanded on with its overcurrent flag high is disabled on the clock edge of the 15th qualifying tick. The flag is visible in the cycle after that edge. After 14 ticks it is still enabled.
- R3: With delay select high (12 ms, 120 ticks), the switch is disabled on the 120th qualifying tick and not before.
- R4: If the overcurrent flag drops before the delay expires, that timer returns to zero. A later overcurrent needs the full delay again.
- R5: A switch that is commanded off ignores its overcurrent flag, holds its timer at zero and never trips. Its delay counts from the cycle in which it is commanded on.
- R6: A disable flag stays high after its overcurrent flag drops and while further ticks arrive, until a status reset.
- R7: The short-detected flag is high exactly when at least one disable flag is high.
- R8: A status-reset pulse clears all disable flags and the short-detected flag together, and restarts every timer from zero. A status reset in the same cycle as an expiring tick wins, and that switch stays enabled.
- R9: Timers are independent. Bit i of every per-switch vector belongs to switch i. One switch tripping leaves the running count of another untouched.
- R10: The delay select is read at every tick. A switch whose count already meets the newly selected terminal count trips on its next qualifying tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Timebase tick, one-cycle pulse per tick period |
| long_dly_i | input | 1 | Delay select: 1 = long delay, 0 = short delay |
| clr_i | input | 1 | Status-reset pulse |
| sw_on_i | input | N_CH | Commanded state of each switch, 1 = on |
| ovc_i | input | N_CH | Overcurrent-limit flag of each switch |
| trip_o | output | N_CH | Disable flag of each switch, 1 = forced off |
| short_o | output | 1 | Short-detected flag |

## Verification
The assertions assume that every input is synchronous to clk_i, and that tick_i and clr_i are single-cycle pulses. They also assume a tick never arrives while a switch's inputs are still settling from a change in the same cycle. The stimulus changes inputs only on the falling clock edge. It raises tick_i for exactly one cycle followed by at least one idle cycle, and it pulses clr_i for one cycle. The only overlap it drives on purpose is a tick coinciding with clr_i, which exercises the clear-over-expiry priority.

// File: rtl/sc_tmr_pkg.sv
package sc_tmr_pkg;

  typedef enum logic {
    DLY_SHORT = 1'b0,
    DLY_LONG  = 1'b1
  } dly_sel_e;

  // ceil(delay / tick), never below one tick
  function automatic int unsigned ticks_for(int unsigned dly_us, int unsigned tick_us);
    int unsigned n;
    n = (dly_us + tick_us - 1) / tick_us;
    return (n == 0) ? 1 : n;
  endfunction

endpackage

// File: rtl/sc_term_sel.sv
module sc_term_sel #(
  parameter int unsigned SHORT_CNT = 15,
  parameter int unsigned LONG_CNT  = 120,
  parameter int unsigned CNT_W     = 7
) (
  input  logic             long_dly_i,
  output logic [CNT_W-1:0] term_o
);
  import sc_tmr_pkg::*;

  dly_sel_e sel;
  assign sel = dly_sel_e'(long_dly_i);

  always_comb begin
    unique case (sel)
      DLY_LONG: term_o = CNT_W'(LONG_CNT);
      default:  term_o = CNT_W'(SHORT_CNT);
    endcase
  end

  always_comb begin
    a_term_nonzero_r2: assert (term_o != '0);
  end

endmodule

// File: rtl/sc_chan_tmr.sv
module sc_chan_tmr #(
  parameter int unsigned CNT_W    = 7,
  parameter int unsigned LONG_CNT = 120
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             clr_i,
  input  logic             sw_on_i,
  input  logic             ovc_i,
  input  logic [CNT_W-1:0] term_i,
  output logic             trip_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   cnt_nxt;
  logic             qual;
  logic             expire;

  assign qual    = sw_on_i & ovc_i;
  assign cnt_nxt = {1'b0, cnt_q} + (CNT_W+1)'(1);
  assign expire  = cnt_nxt >= {1'b0, term_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      trip_o <= 1'b0;
    end else if (clr_i) begin
      cnt_q  <= '0;
      trip_o <= 1'b0;
    end else if (trip_o || !qual) begin
      cnt_q  <= '0;
    end else if (tick_i) begin
      if (expire) begin
        cnt_q  <= '0;
        trip_o <= 1'b1;
      end else begin
        cnt_q  <= cnt_nxt[CNT_W-1:0];
      end
    end
  end

  p_off_holds_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sw_on_i |=> cnt_q == '0);

  p_drop_restarts_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ovc_i |=> cnt_q == '0);

  p_trip_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trip_o && !clr_i |=> trip_o);

  p_trip_cause_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(trip_o) |-> $past(sw_on_i && ovc_i && tick_i && !clr_i));

  p_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !trip_o && cnt_q == '0);

  p_cnt_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CNT_W'(LONG_CNT));

endmodule

// File: rtl/sc_trip_or.sv
module sc_trip_or #(
  parameter int unsigned N_CH = 12
) (
  input  logic [N_CH-1:0] trip_i,
  output logic            short_o
);
  assign short_o = |trip_i;
endmodule

// File: rtl/sc_shutdown_array.sv
module sc_shutdown_array #(
  parameter int unsigned N_CH     = 12,
  parameter int unsigned TICK_US  = 100,
  parameter int unsigned SHORT_US = 1500,
  parameter int unsigned LONG_US  = 12000
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic            long_dly_i,
  input  logic            clr_i,
  input  logic [N_CH-1:0] sw_on_i,
  input  logic [N_CH-1:0] ovc_i,
  output logic [N_CH-1:0] trip_o,
  output logic            short_o
);
  import sc_tmr_pkg::*;

  localparam int unsigned SHORT_CNT = ticks_for(SHORT_US, TICK_US);
  localparam int unsigned LONG_CNT  = ticks_for(LONG_US, TICK_US);
  localparam int unsigned MAX_CNT   = (LONG_CNT > SHORT_CNT) ? LONG_CNT : SHORT_CNT;
  localparam int unsigned CNT_W     = $clog2(MAX_CNT + 1);

  logic [CNT_W-1:0] term;

  sc_term_sel #(
    .SHORT_CNT(SHORT_CNT),
    .LONG_CNT (LONG_CNT),
    .CNT_W    (CNT_W)
  ) u_term (
    .long_dly_i(long_dly_i),
    .term_o    (term)
  );

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    sc_chan_tmr #(
      .CNT_W   (CNT_W),
      .LONG_CNT(MAX_CNT)
    ) u_tmr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .tick_i (tick_i),
      .clr_i  (clr_i),
      .sw_on_i(sw_on_i[g]),
      .ovc_i  (ovc_i[g]),
      .term_i (term),
      .trip_o (trip_o[g])
    );
  end

  sc_trip_or #(.N_CH(N_CH)) u_or (
    .trip_i (trip_o),
    .short_o(short_o)
  );

  p_short_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !short_o);

  p_short_rise_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(short_o) |-> $past(tick_i && !clr_i));

  p_short_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    short_o && !clr_i |=> short_o);

  p_no_spurious_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i && !clr_i |=> $stable(trip_o));

endmodule

// File: tb/sim_sc_shutdown_array.sv
module sim_sc_shutdown_array;
  localparam time CLK_PERIOD = 10ns;
  localparam int  N = 12;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         tick = 1'b0;
  logic         long_dly = 1'b0;
  logic         clr = 1'b0;
  logic [N-1:0] sw_on = '0;
  logic [N-1:0] ovc = '0;
  logic [N-1:0] trip;
  logic         short_flag;

  always #(CLK_PERIOD/2) clk = ~clk;

  sc_shutdown_array u0 (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .tick_i    (tick),
    .long_dly_i(long_dly),
    .clr_i     (clr),
    .sw_on_i   (sw_on),
    .ovc_i     (ovc),
    .trip_o    (trip),
    .short_o   (short_flag)
  );

  typedef struct {
    int unsigned  cyc;
    logic [N-1:0] trip;
    logic         sh;
    string        tag;
  } exp_t;

  exp_t        q[$];
  exp_t        cur;
  int unsigned cyc = 0;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compare queued expectations when their cycle comes up
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      cur = q.pop_front();
      n_chk++;
      if (trip !== cur.trip || short_flag !== cur.sh) begin
        n_fail++;
        $display("FAIL %s: trip=%03h short=%0b expected trip=%03h short=%0b",
                 cur.tag, trip, short_flag, cur.trip, cur.sh);
      end
    end
  end

  task automatic chk(input logic [N-1:0] t, input logic s, input string tag);
    exp_t e;
    e.cyc = cyc + 1; e.trip = t; e.sh = s; e.tag = tag;
    q.push_back(e);
    @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
    end
  endtask

  task automatic pulse_clr();
    @(negedge clk) clr = 1'b1;
    @(negedge clk) clr = 1'b0;
  endtask

  task automatic quiet();
    sw_on = '0; ovc = '0;
    pulse_clr();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk('0, 1'b0, "R1 reset state");

    // R2, R7: short delay on switch 3
    sw_on[3] = 1'b1; ovc[3] = 1'b1;
    ticks(14);
    chk('0, 1'b0, "R2 enabled after 14 ticks");
    ticks(1);
    chk(12'h008, 1'b1, "R2 R7 tripped on 15th tick");

    // R6: latch survives flag drop and more ticks
    ovc[3] = 1'b0;
    ticks(3);
    chk(12'h008, 1'b1, "R6 trip latched");

    pulse_clr();
    chk('0, 1'b0, "R8 clear re-enables");
    quiet();

    // R4: drop before expiry restarts
    sw_on[1] = 1'b1; ovc[1] = 1'b1;
    ticks(14);
    ovc[1] = 1'b0;
    ticks(1);
    ovc[1] = 1'b1;
    ticks(14);
    chk('0, 1'b0, "R4 count restarted");
    ticks(1);
    chk(12'h002, 1'b1, "R4 full delay trips");
    quiet();

    // R5: commanded-off switch ignores flag
    ovc[7] = 1'b1;
    ticks(30);
    chk('0, 1'b0, "R5 off switch ignored");
    sw_on[7] = 1'b1;
    ticks(14);
    chk('0, 1'b0, "R5 delay from switch-on");
    ticks(1);
    chk(12'h080, 1'b1, "R5 trips after full delay");
    quiet();

    // R3: long delay
    long_dly = 1'b1;
    sw_on[10] = 1'b1; ovc[10] = 1'b1;
    ticks(119);
    chk('0, 1'b0, "R3 enabled after 119 ticks");
    ticks(1);
    chk(12'h400, 1'b1, "R3 tripped on 120th tick");
    quiet();

    // R10: switch delay mid-count
    sw_on[2] = 1'b1; ovc[2] = 1'b1;
    ticks(20);
    chk('0, 1'b0, "R10 long mode still counting");
    long_dly = 1'b0;
    ticks(1);
    chk(12'h004, 1'b1, "R10 trips on next tick after select");
    quiet();

    // R9: independent channels
    sw_on[0] = 1'b1; ovc[0] = 1'b1;
    ticks(10);
    sw_on[5] = 1'b1; ovc[5] = 1'b1;
    ticks(5);
    chk(12'h001, 1'b1, "R9 switch 0 trips alone");
    ticks(9);
    chk(12'h001, 1'b1, "R9 switch 5 still counting");
    ticks(1);
    chk(12'h021, 1'b1, "R9 switch 5 trips on own count");

    // R8: clear all together, restart, clear beats expiry
    pulse_clr();
    chk('0, 1'b0, "R8 all cleared together");
    ticks(14);
    @(negedge clk) begin tick = 1'b1; clr = 1'b1; end
    @(negedge clk) begin tick = 1'b0; clr = 1'b0; end
    chk('0, 1'b0, "R8 clear wins over expiry");
    ticks(14);
    chk('0, 1'b0, "R8 count restarted after clear");
    ticks(1);
    chk(12'h021, 1'b1, "R8 R7 both trip again");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule